// File: doc/BRIEF.md
# Capture and Auto-Reload Up/Down Timer

A 16-bit counter with a 16-bit capture/reload register and two sticky flags: an overflow flag and an external-event flag. It advances on a machine-cycle enable strobe. In timer function it steps once per strobe. In counter function it steps once for each falling edge seen on an external count pin. A second external pin, the trigger pin, has one of three roles, set by the control bits:

- In capture mode, a falling edge copies the running count into the capture register.
- In auto-reload mode, a falling edge forces a reload of the count.
- In up/down mode, the trigger pin's level sets the count direction.

Software reads and writes the count, the capture/reload value and a five-bit control word through plain register ports. It clears the flags with a per-flag clear strobe. Both pins pass through a two-stage synchronizer and a sample register, all clocked only on the machine-cycle strobe. An edge is therefore one sample reading high followed by the next reading low. A single interrupt request combines the flags.

Top module: `updown_capture_timer`

## Requirements
- R1: After reset the count, the capture/reload value, the control word and both flags are zero, and `irq` is low.
- R2: With control bit 0 (run) set and bit 1 (counter function) clear, the count rises by one on each cycle where `mc_tick` is high. It holds its value on every other cycle.
- R3: With bits 0 and 1 set, the count steps once for each high-then-low pair of successive `cnt_pin` samples. The step lands on the third `mc_tick` after the pin falls. A pin held low gives no further steps.
- R4: With bit 2 (capture mode) set, a step from 0xFFFF wraps the count to 0x0000 and sets `ovf_flag`.
- R5: In capture mode with bit 3 (external enable) set, a `trig_pin` falling edge copies the count into the capture register and sets `ext_flag`. The copy lands on the third `mc_tick` after the fall and does not depend on run. With bit 3 clear, the edge changes neither.
- R6: In reload mode (bit 2 clear, bit 4 clear), a step from 0xFFFF loads the count from the reload register and sets `ovf_flag`.
- R7: In reload mode with bit 3 set, a `trig_pin` falling edge loads the count from the reload register and sets `ext_flag`.
- R8: In up/down mode (bit 2 clear, bit 4 set), a high sampled `trig_pin` counts up and a low one counts down. Counting down, a step taken while the count equals the reload value loads 0xFFFF and sets `ovf_flag`.
- R9: In up/down mode, `ext_flag` toggles on every overflow and underflow. It does not drive `irq` in this mode.
- R10: A count write takes priority over a step in the same cycle. Flags stay set until cleared through `flag_clr` (bit 0 clears `ovf_flag`, bit 1 clears `ext_flag`).
- R11: Outside up/down mode, `irq` is high whenever either flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle enable strobe |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | External trigger / direction input |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | 5 | Control word: 0 run, 1 counter function, 2 capture mode, 3 external enable, 4 down-count enable |
| ctl_q | output | 5 | Control word |
| cnt_we | input | 1 | Count write enable |
| cnt_wdata | input | W | Count write value |
| cnt_q | output | W | Current count |
| rld_we | input | 1 | Capture/reload write enable |
| rld_wdata | input | W | Capture/reload write value |
| rld_q | output | W | Capture/reload value |
| flag_clr | input | 2 | Flag clear strobes |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | External event flag, or 17th bit in up/down mode |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the underflow compare in up/down mode. The direction comes from a synchronized pin level, and the wrap value comes from the reload register rather than zero. The stimulus therefore stops the timer and parks `trig_pin` low. It waits out the three sample stages so the direction is settled. It then presets the count two steps above the reload value and restarts the timer. This makes the compare land on a known tick, so the bench can check the 0xFFFF load and the toggled external flag there. The same setup is repeated with the pin high to wrap the count upward. That second pass shows the flag toggling back and `irq` ignoring it.

// File: rtl/updown_capture_timer.sv
module updown_capture_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mc_tick,
  input  logic         cnt_pin,
  input  logic         trig_pin,
  input  logic         ctl_we,
  input  logic [4:0]   ctl_wdata,
  output logic [4:0]   ctl_q,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wdata,
  output logic [W-1:0] cnt_q,
  input  logic         rld_we,
  input  logic [W-1:0] rld_wdata,
  output logic [W-1:0] rld_q,
  input  logic [1:0]   flag_clr,
  output logic         ovf_flag,
  output logic         ext_flag,
  output logic         irq
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] TOPV = '1;

  logic [2:0] cp_sh, tp_sh;
  logic cnt_fall, trg_fall, run, evt, capm, exen, ud, up, step, trg_ev, wrap;
  logic [W-1:0] cnt_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cp_sh <= '0;
      tp_sh <= '0;
    end else if (mc_tick) begin
      cp_sh <= {cp_sh[1:0], cnt_pin};
      tp_sh <= {tp_sh[1:0], trig_pin};
    end
  end

  assign cnt_fall = cp_sh[2] & ~cp_sh[1];
  assign trg_fall = tp_sh[2] & ~tp_sh[1];
  assign run  = ctl_q[0];
  assign evt  = ctl_q[1];
  assign capm = ctl_q[2];
  assign exen = ctl_q[3];
  assign ud   = ~capm & ctl_q[4];
  assign up   = ~ud | tp_sh[1];
  assign step = mc_tick & run & (evt ? cnt_fall : 1'b1);
  assign trg_ev = mc_tick & exen & trg_fall & ~ud;
  assign wrap = step & (up ? (cnt_q == TOPV) : (cnt_q == rld_q));
  assign irq  = ovf_flag | (ext_flag & ~ud);

  always_comb begin
    cnt_n = cnt_q;
    if (step) cnt_n = up ? cnt_q + ONE : cnt_q - ONE;
    if (wrap && !capm) cnt_n = up ? rld_q : TOPV;
    if (trg_ev && !capm) cnt_n = rld_q;
    if (cnt_we) cnt_n = cnt_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      cnt_q    <= '0;
      rld_q    <= '0;
      ovf_flag <= 1'b0;
      ext_flag <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_wdata;
      cnt_q <= cnt_n;
      if (rld_we) rld_q <= rld_wdata;
      else if (trg_ev && capm) rld_q <= cnt_q;
      if (wrap) ovf_flag <= 1'b1;
      else if (flag_clr[0]) ovf_flag <= 1'b0;
      if (ud && wrap) ext_flag <= ~ext_flag;
      else if (trg_ev) ext_flag <= 1'b1;
      else if (flag_clr[1]) ext_flag <= 1'b0;
    end
  end

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_tick && !cnt_we) |=> $stable(cnt_q));

  // R4
  cap_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_tick && run && !evt && capm && !cnt_we && cnt_q == TOPV) |=> (ovf_flag && cnt_q == '0));

  // R5
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_tick && capm && exen && tp_sh[2] && !tp_sh[1] && !rld_we) |=> (rld_q == $past(cnt_q) && ext_flag));

  // R8
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_tick && run && !evt && ud && !tp_sh[1] && !cnt_we && cnt_q == rld_q) |=> (cnt_q == TOPV && ovf_flag));

  // R9
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_tick && run && !evt && ud && !tp_sh[1] && !cnt_we && cnt_q == rld_q) |=> (ext_flag != $past(ext_flag)));

  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr[0]) |=> ovf_flag);
endmodule

// File: tb/updown_capture_timer_tb_top.sv
module updown_capture_timer_tb_top;
  logic clk = 0, rst_n = 0;
  logic cnt_pin = 1, trig_pin = 1;
  logic ctl_we = 0, cnt_we = 0, rld_we = 0;
  logic [4:0] ctl_wdata = 0, ctl_q;
  logic [15:0] cnt_wdata = 0, rld_wdata = 0, cnt_q, rld_q;
  logic [1:0] flag_clr = 0;
  logic ovf_flag, ext_flag, irq, mc_tick;
  logic [1:0] ph = 0;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct { string req; int sel; logic [15:0] exp; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) ph <= ph + 2'd1;
  assign mc_tick = (ph == 2'd3);

  updown_capture_timer #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
    .rld_we(rld_we), .rld_wdata(rld_wdata), .rld_q(rld_q),
    .flag_clr(flag_clr), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq));

  function automatic logic [15:0] observe(int sel);
    case (sel)
      0: return cnt_q;
      1: return rld_q;
      2: return {15'd0, ovf_flag};
      3: return {15'd0, ext_flag};
      4: return {15'd0, irq};
      default: return {11'd0, ctl_q};
    endcase
  endfunction

  initial begin
    forever begin
      wait (sb.size() != 0);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        act = observe(it.sel);
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(string r, int sel, logic [15:0] e);
    item_t it;
    it.req = r; it.sel = sel; it.exp = e;
    sb.push_back(it);
  endtask

  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin
      while (!mc_tick) @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr_ctl(logic [4:0] v);
    ctl_wdata = v; ctl_we = 1; @(negedge clk); ctl_we = 0;
  endtask
  task automatic wr_cnt(logic [15:0] v);
    cnt_wdata = v; cnt_we = 1; @(negedge clk); cnt_we = 0;
  endtask
  task automatic wr_rld(logic [15:0] v);
    rld_wdata = v; rld_we = 1; @(negedge clk); rld_we = 0;
  endtask
  task automatic clr(logic [1:0] v);
    flag_clr = v; @(negedge clk); flag_clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_v("R1", 0, 16'h0); expect_v("R1", 1, 16'h0); expect_v("R1", 2, 0);
    expect_v("R1", 3, 0); expect_v("R1", 4, 0); expect_v("R1", 5, 0);

    // R2 timer function
    wr_cnt(16'h0010); wr_ctl(5'b00001); tk(5);
    expect_v("R2", 0, 16'h0015);
    repeat (2) @(negedge clk);
    expect_v("R2", 0, 16'h0015);

    // R10 count write wins over a step
    while (!mc_tick) @(negedge clk);
    wr_cnt(16'h0300);
    expect_v("R10", 0, 16'h0300);

    // R4 capture mode wrap, R11 irq, R10 sticky
    wr_ctl(5'b00100); wr_cnt(16'hFFFE); clr(2'b11); wr_ctl(5'b00101); tk(2);
    expect_v("R4", 0, 16'h0000); expect_v("R4", 2, 1); expect_v("R11", 4, 1);
    tk(3);
    expect_v("R10", 2, 1); expect_v("R4", 0, 16'h0003);
    wr_ctl(5'b00100); clr(2'b01);
    expect_v("R10", 2, 0); expect_v("R11", 4, 0);

    // R5 capture on trigger edge
    wr_ctl(5'b01100); wr_cnt(16'h1234); wr_rld(16'hAAAA); clr(2'b11);
    trig_pin = 0; tk(2);
    expect_v("R5", 1, 16'hAAAA); expect_v("R5", 3, 0);
    tk(1);
    expect_v("R5", 1, 16'h1234); expect_v("R5", 3, 1); expect_v("R11", 4, 1);
    trig_pin = 1; tk(3);
    wr_ctl(5'b00100); clr(2'b11); wr_cnt(16'h4321);
    trig_pin = 0; tk(4);
    expect_v("R5", 1, 16'h1234); expect_v("R5", 3, 0);
    trig_pin = 1; tk(3);

    // R3 counter function
    wr_ctl(5'b00000); wr_cnt(16'h0000); wr_ctl(5'b00011);
    cnt_pin = 0; tk(2);
    expect_v("R3", 0, 16'h0000);
    tk(1);
    expect_v("R3", 0, 16'h0001);
    tk(4);
    expect_v("R3", 0, 16'h0001);
    cnt_pin = 1; tk(3); cnt_pin = 0; tk(3);
    expect_v("R3", 0, 16'h0002);
    cnt_pin = 1;

    // R6 reload on overflow
    wr_ctl(5'b00000); wr_rld(16'h8000); wr_cnt(16'hFFFD); clr(2'b11);
    wr_ctl(5'b00001); tk(2);
    expect_v("R6", 0, 16'hFFFF); expect_v("R6", 2, 0);
    tk(1);
    expect_v("R6", 0, 16'h8000); expect_v("R6", 2, 1);

    // R7 reload on trigger edge
    wr_ctl(5'b01000); wr_rld(16'h5555); wr_cnt(16'h0777); clr(2'b11);
    trig_pin = 0; tk(3);
    expect_v("R7", 0, 16'h5555); expect_v("R7", 3, 1); expect_v("R11", 4, 1);

    // R8 down count and underflow, R9 toggle and irq masking
    wr_ctl(5'b10000); tk(3);
    wr_rld(16'h0100); wr_cnt(16'h0102); clr(2'b11);
    wr_ctl(5'b10001); tk(1);
    expect_v("R8", 0, 16'h0101);
    tk(1);
    expect_v("R8", 0, 16'h0100); expect_v("R8", 2, 0);
    tk(1);
    expect_v("R8", 0, 16'hFFFF); expect_v("R8", 2, 1); expect_v("R9", 3, 1);
    clr(2'b01);
    expect_v("R9", 3, 1); expect_v("R9", 4, 0);
    wr_ctl(5'b10000);
    trig_pin = 1; tk(3);
    wr_cnt(16'hFFFE); wr_ctl(5'b10001); tk(1);
    expect_v("R8", 0, 16'hFFFF);
    tk(1);
    expect_v("R8", 0, 16'h0100); expect_v("R8", 2, 1); expect_v("R9", 3, 0);
    wr_ctl(5'b10000);

    @(negedge clk);
    wait (sb.size() == 0);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule